// File: doc/BRIEF.md
# Delay Length Code Loader

This block produces the 11-bit length code that sets a variable video line delay. The code comes from one of two sources, chosen by a mode input. In parallel mode the code is read from eleven configuration pins. In serial mode the three lowest of those pins carry a serial data line, a shift clock and a latch strobe. The higher eight pins are then unused.

A serial word is clocked into a shift register, MSB first, on the rising edges of the shift clock. A rising edge of the latch strobe then commits it to a holding register. Both the shift clock and the latch strobe are unrelated to the delay clock. The committed word is therefore carried into the delay-clock domain by a toggle handshake. The delay clock takes the word only after the toggle has passed through a synchroniser. The delay length that the code selects is 31 plus the code.

Top module: `dly_len_loader`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, `code_o` becomes 0. The shift and holding registers are cleared at once, so serial mode after reset yields code 0.
- R2: With `par_mode` high, `code_o` equals the value of `len_pins` from two rising `clk` edges earlier. This includes the boundary codes 0 and 2047.
- R3: In serial mode, `len_pins[0]` is serial data and is shifted in on each rising edge of `len_pins[1]`. The first bit sent becomes code bit 10 and the last becomes bit 0, so a word with only the last bit set gives code 1 (delay 32).
- R4: Shifting alone never changes `code_o`. Only a rising edge of `len_pins[2]` commits the shift register to the holding register.
- R5: In serial mode, changes on `len_pins[10:3]` have no effect on `code_o`.
- R6: A committed word appears at `code_o` on the fourth rising `clk` edge after the latch edge (synchroniser depth 2 plus two registers), and not before. `code_o` only ever takes whole committed words.
- R7: Changing `par_mode` switches `code_o` in one step between the registered parallel word and the last committed serial word. The serial word survives a period in parallel mode as long as `len_pins[2]` does not rise during it.
- R8: When more than 11 bits are shifted before a latch, only the last 11 bits form the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Delay clock |
| rst | input | 1 | Active-high reset; synchronous for delay-clock logic, immediate clear for serial registers |
| par_mode | input | 1 | 1 selects parallel code, 0 selects serial interface |
| len_pins | input | 11 | Parallel code; in serial mode bit 0 data, bit 1 shift clock, bit 2 latch strobe |
| code_o | output | 11 | Registered length code in the delay-clock domain |

## Verification
The bench times the handshake to the exact edge. A design with too short a synchroniser, or one that read the holding register without waiting, would show the new word early. A missing stage would show it late. Bursts of shift edges with no latch, and activity on the eight unused pins, must leave the code untouched. A design that shifted straight into the output, or decoded all pins in both modes, would change it. Words of thirteen bits and a single set final bit check bit order and truncation. A reversed shift direction would show code 1024 where 1 is expected. Mode switches with a committed word pending check that the serial word is retained and that no mixed value appears.

// File: rtl/dly_len_pkg.sv
package dly_len_pkg;
  localparam int unsigned LEN_CODE_W   = 11;
  localparam int unsigned LEN_SYNC_DEP = 2;
  // Pin roles in serial mode
  localparam int unsigned PIN_SDATA = 0;
  localparam int unsigned PIN_SCLK  = 1;
  localparam int unsigned PIN_LATCH = 2;
  localparam int unsigned LEN_BASE  = 31;
endpackage

// File: rtl/len_shift.sv
module len_shift #(
  parameter int unsigned W = 11
) (
  input  logic         sclk,
  input  logic         clr,
  input  logic         sdata,
  output logic [W-1:0] word
);
  // MSB first: each new bit enters at bit 0 and older bits move up
  always_ff @(posedge sclk or posedge clr) begin
    if (clr) word <= '0;
    else     word <= {word[W-2:0], sdata};
  end
endmodule

// File: rtl/len_hold.sv
module len_hold #(
  parameter int unsigned W = 11
) (
  input  logic         latch,
  input  logic         clr,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out,
  output logic         flag
);
  always_ff @(posedge latch or posedge clr) begin
    if (clr) begin
      word_out <= '0;
      flag     <= 1'b0;
    end else begin
      word_out <= word_in;
      flag     <= ~flag;
    end
  end
endmodule

// File: rtl/len_xfer.sv
module len_xfer #(
  parameter int unsigned W      = 11,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flag_in,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_out,
  output logic         upd
);
  localparam int unsigned TOP = STAGES - 1;
  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= flag_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign upd = sync_q[TOP] ^ seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= 1'b0;
      word_out <= '0;
    end else if (upd) begin
      seen_q   <= sync_q[TOP];
      word_out <= word_in;
    end
  end
endmodule

// File: rtl/dly_len_loader.sv
module dly_len_loader
  import dly_len_pkg::*;
#(
  parameter int unsigned CODE_W = LEN_CODE_W,
  parameter int unsigned SYNC_N = LEN_SYNC_DEP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic [CODE_W-1:0] len_pins,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] shift_w;
  logic [CODE_W-1:0] hold_w;
  logic              flag_w;
  logic [CODE_W-1:0] ser_r;
  logic              upd_w;
  logic [CODE_W-1:0] par_r;
  logic              mode_r;

  len_shift #(.W(CODE_W)) i_shift (
    .sclk (len_pins[PIN_SCLK]),
    .clr  (rst),
    .sdata(len_pins[PIN_SDATA]),
    .word (shift_w)
  );

  len_hold #(.W(CODE_W)) i_hold (
    .latch   (len_pins[PIN_LATCH]),
    .clr     (rst),
    .word_in (shift_w),
    .word_out(hold_w),
    .flag    (flag_w)
  );

  len_xfer #(.W(CODE_W), .STAGES(SYNC_N)) i_xfer (
    .clk     (clk),
    .rst     (rst),
    .flag_in (flag_w),
    .word_in (hold_w),
    .word_out(ser_r),
    .upd     (upd_w)
  );

  // Mode and parallel word registered together so a switch picks one whole word
  always_ff @(posedge clk) begin
    if (rst) begin
      par_r  <= '0;
      mode_r <= 1'b0;
      code_o <= '0;
    end else begin
      par_r  <= len_pins;
      mode_r <= par_mode;
      code_o <= mode_r ? par_r : ser_r;
    end
  end
endmodule

// File: rtl/dly_len_loader_chk.sv
module dly_len_loader_chk #(
  parameter int unsigned W = 11
) (
  input logic         clk,
  input logic         rst,
  input logic         mode_r,
  input logic [W-1:0] par_r,
  input logic [W-1:0] ser_r,
  input logic [W-1:0] hold_w,
  input logic         upd_w,
  input logic [W-1:0] code_o
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> code_o == '0);

  a_r2_par_word: assert property (@(posedge clk) disable iff (rst)
    mode_r |=> code_o == $past(par_r));

  a_r7_ser_word: assert property (@(posedge clk) disable iff (rst)
    !mode_r |=> code_o == $past(ser_r));

  a_r6_only_on_handshake: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_r) |-> $past(upd_w));

  a_r4_word_settled: assert property (@(posedge clk) disable iff (rst)
    upd_w |-> $stable(hold_w));
endmodule

bind dly_len_loader dly_len_loader_chk #(.W(CODE_W)) i_chk (
  .clk   (clk),
  .rst   (rst),
  .mode_r(mode_r),
  .par_r (par_r),
  .ser_r (ser_r),
  .hold_w(hold_w),
  .upd_w (upd_w),
  .code_o(code_o)
);

// File: tb/test_dly_len_loader.sv
module test_dly_len_loader;
  localparam int W = 11;
  logic         clk = 1'b0;
  logic         rst;
  logic         par_mode;
  logic [W-1:0] len_pins;
  logic [W-1:0] code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] cur_exp;
  bit mon_on = 0;

  always #4 clk = ~clk;

  dly_len_loader i_dly_len_loader (
    .clk(clk), .rst(rst), .par_mode(par_mode),
    .len_pins(len_pins), .code_o(code_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_next(input logic [W-1:0] v);
    if (v !== cur_exp) begin
      exp_q.push_back(v);
      cur_exp = v;
    end
  endtask

  // Monitor: every change of code_o must match the next expected word
  logic [W-1:0] last_seen;
  always @(negedge clk) begin
    if (mon_on && code_o !== last_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 actual %0d expected no change", code_o);
      end else begin
        chk("R6 scoreboard", code_o, exp_q.pop_front());
      end
      last_seen = code_o;
    end
  end

  task automatic shift_bits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      len_pins[0] = bits[i];
      #5 len_pins[1] = 1'b1;
      #10 len_pins[1] = 1'b0;
      #5;
    end
  endtask

  // Latch and time the arrival: unchanged after 3 edges, new after 4 (R6)
  task automatic latch_timed(input logic [W-1:0] old, input logic [W-1:0] nw);
    @(negedge clk);
    len_pins[2] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
    end
    chk("R6 not early", code_o, old);
    @(posedge clk); @(negedge clk);
    chk("R6 arrival", code_o, nw);
    len_pins[2] = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; par_mode = 1'b0; len_pins = '0; cur_exp = '0;
    wait_clks(4);
    chk("R1 reset", code_o, 11'd0);
    rst = 1'b0;
    wait_clks(4);
    chk("R1 serial after reset", code_o, 11'd0);
    last_seen = code_o;
    mon_on = 1;

    // R3: single final bit gives code 1
    shift_bits(16'h0001, 11);
    expect_next(11'd1);
    latch_timed(11'd0, 11'd1);
    wait_clks(2);

    // R3: pattern with MSB first
    shift_bits(16'h0435, 11);
    expect_next(11'h435);
    latch_timed(11'd1, 11'h435);

    // R4: shift without latch leaves code alone
    shift_bits(16'h07FF, 11);
    wait_clks(8);
    chk("R4 shift only", code_o, 11'h435);
    expect_next(11'h7FF);
    latch_timed(11'h435, 11'h7FF);

    // R5: unused pins in serial mode
    for (int p = 1; p < 6; p++) begin
      len_pins[10:3] = 8'(p * 53);
      wait_clks(3);
    end
    chk("R5 unused pins", code_o, 11'h7FF);
    len_pins = '0;

    // R8: 13 bits, last 11 kept
    shift_bits(16'h1A5B, 13);
    expect_next(11'h25B);
    latch_timed(11'h7FF, 11'h25B);
    wait_clks(2);

    // R7: switch to parallel and back, serial word kept
    @(negedge clk);
    par_mode = 1'b1; len_pins = 11'h5A9;
    expect_next(11'h5A9);
    wait_clks(3);
    chk("R7 to parallel", code_o, 11'h5A9);
    par_mode = 1'b0; len_pins = '0;
    expect_next(11'h25B);
    wait_clks(3);
    chk("R7 back to serial", code_o, 11'h25B);

    // R2: parallel patterns with exact latency
    par_mode = 1'b1;
    expect_next(11'd0);
    wait_clks(3);
    chk("R2 code zero", code_o, 11'd0);
    begin
      logic [W-1:0] pats [5] = '{11'h7FF, 11'h400, 11'h001, 11'h2AA, 11'h155};
      logic [W-1:0] prev;
      prev = 11'd0;
      foreach (pats[i]) begin
        @(negedge clk);
        len_pins = pats[i];
        expect_next(pats[i]);
        @(posedge clk); @(negedge clk);
        chk("R2 one edge", code_o, prev);
        @(posedge clk); @(negedge clk);
        chk("R2 two edges", code_o, pats[i]);
        prev = pats[i];
      end
    end
    wait_clks(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 actual %0d pending expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule